// File: doc/BRIEF.md
# Fractional Square-Wave Clock Generator

This block makes a square wave whose frequency is a 16-bit fraction of a selectable reference rate. The wave is meant to drive a general-purpose pin. The reference is one of eight power-of-two divisions of the 20 MHz system clock. A phase accumulator adds the frequency word once per reference period, and the wave is the accumulator's top bit. The output frequency is therefore (freq / 65536) × reference, with reference = 20 MHz / 2^k for select code k in 0..7. This gives references from 20 MHz down to 156.25 kHz.

The host sets a frequency word and a reference select, then pulses a load strobe to make them current. The current pair can always be read back. An enable input turns the generator on and off. While it is off, the wave is low and all phase state is cleared, so each new run starts from phase zero.

Top module: `fsq_clkgen`

## Requirements
- R1: After synchronous reset, `wave_out` is 0 and both readbacks (`freq_rb`, `sel_rb`) are 0.
- R2: A cycle with `load` high copies `freq_word` and `ref_sel` into the current settings, and the readbacks show them from the next cycle. When `load` is low, changes on `freq_word` and `ref_sel` do not alter the readbacks or the wave.
- R3: The reference enable is produced by a free-running prescaler counter. The counter is zero on the first enabled cycle and counts up by one each enabled cycle. For select code k, a reference enable occurs in each enabled cycle whose counter value has its low k bits all ones, which is once every 2^k cycles. For k = 0 it occurs in every enabled cycle.
- R4: Each reference enable adds the current frequency word, modulo 65536, to a 16-bit accumulator that starts at 0. `wave_out` is the accumulator's most significant bit. With a word F below 32768 and T reference enables since start, the wave shows floor((T·F + 32768) / 65536) rising edges.
- R5: A frequency word of 0 keeps `wave_out` constantly low for the whole run.
- R6: With `enable` low, `wave_out` is low from the next cycle on, and the accumulator and prescaler are cleared. A later run with the same settings gives the same edge count as the first run.
- R7: A load while running takes effect at the next reference enable. If a reference enable falls in the same cycle as the load, that enable still adds the old word.
- R8: `wave_out` is registered and changes only in a cycle after a reference enable. Each high or low phase lasts at least one system clock.
- R9: With word 32768 and select 0, the wave toggles every system clock. N enabled cycles give floor((N + 1) / 2) rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Generator on (1) / off and cleared (0) |
| load | input | 1 | Strobe that captures `freq_word` and `ref_sel` |
| freq_word | input | 16 | Requested frequency word |
| ref_sel | input | 3 | Requested reference select k (20 MHz / 2^k) |
| wave_out | output | 1 | Square wave |
| freq_rb | output | 16 | Current frequency word |
| sel_rb | output | 3 | Current reference select |

## Verification
The load strobe and a reference enable can land on the same clock edge. In that case the accumulator must add the word that was current before the strobe. The bench causes this deliberately by placing the load on an edge index of the form m·2^k − 1, which is a reference-enable edge. It also places loads at random edges. It judges the outcome by comparing the exact rising-edge count over the whole window with a sum that switches words after the load edge. Runs with random words and selects, and corner runs at word 0 and word 32768, are checked against the same closed formula.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int unsigned FSQ_ACC_W = 16;
  localparam int unsigned FSQ_SEL_W = 3;

  // prescaler width needed to serve the slowest select code
  function automatic int unsigned pre_width(input int unsigned sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/fsq_settings.sv
module fsq_settings #(
  parameter int unsigned ACC_W = fsq_pkg::FSQ_ACC_W,
  parameter int unsigned SEL_W = fsq_pkg::FSQ_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] freq_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic [ACC_W-1:0] freq_cur,
  output logic [SEL_W-1:0] sel_cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freq_cur <= '0;
      sel_cur  <= '0;
    end else if (load) begin
      freq_cur <= freq_in;
      sel_cur  <= sel_in;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (freq_cur == $past(freq_in)) && (sel_cur == $past(sel_in)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(freq_cur) && $stable(sel_cur));
endmodule

// File: rtl/fsq_prescaler.sv
module fsq_prescaler #(
  parameter int unsigned SEL_W = fsq_pkg::FSQ_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned PRE_W = fsq_pkg::pre_width(SEL_W);

  logic [PRE_W-1:0] cnt;
  logic [NSEL-1:0]  tick_vec;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // one candidate enable per select code: low k counter bits all ones
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    if (g == 0) begin : g_full
      assign tick_vec[g] = 1'b1;
    end else begin : g_div
      assign tick_vec[g] = &cnt[g-1:0];
    end
  end

  assign tick = en & tick_vec[sel];

  assert_clear_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
  assert_full_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (en && sel == '0) |-> tick);
  assert_no_tick_off_R3: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);
endmodule

// File: rtl/fsq_phase_acc.sv
module fsq_phase_acc #(
  parameter int unsigned ACC_W = fsq_pkg::FSQ_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [ACC_W-1:0] step,
  output logic             msb
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || !en)  acc <= '0;
    else if (tick)   acc <= acc + step;
  end

  assign msb = acc[ACC_W-1];

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(acc));
  assert_zero_step_R5: assert property (@(posedge clk) disable iff (rst)
    (en && step == '0) |=> $stable(acc));
  assert_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == '0));
endmodule

// File: rtl/fsq_clkgen.sv
module fsq_clkgen #(
  parameter int unsigned ACC_W = fsq_pkg::FSQ_ACC_W,
  parameter int unsigned SEL_W = fsq_pkg::FSQ_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             load,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [SEL_W-1:0] ref_sel,
  output logic             wave_out,
  output logic [ACC_W-1:0] freq_rb,
  output logic [SEL_W-1:0] sel_rb
);
  logic [ACC_W-1:0] freq_cur;
  logic [SEL_W-1:0] sel_cur;
  logic             ref_tick;

  fsq_settings #(.ACC_W(ACC_W), .SEL_W(SEL_W)) u_set (
    .clk(clk), .rst(rst), .load(load),
    .freq_in(freq_word), .sel_in(ref_sel),
    .freq_cur(freq_cur), .sel_cur(sel_cur)
  );

  fsq_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .en(enable), .sel(sel_cur), .tick(ref_tick)
  );

  fsq_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(enable), .tick(ref_tick),
    .step(freq_cur), .msb(wave_out)
  );

  assign freq_rb = freq_cur;
  assign sel_rb  = sel_cur;

  assert_off_low_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !wave_out);
  assert_wave_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (enable && !ref_tick) |=> $stable(wave_out));
  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (freq_rb == $past(freq_word)));
endmodule

// File: tb/fsq_clkgen_tb.sv
module fsq_clkgen_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        enable = 0;
  logic        load = 0;
  logic [15:0] freq_word = 0;
  logic [2:0]  ref_sel = 0;
  logic        wave_out;
  logic [15:0] freq_rb;
  logic [2:0]  sel_rb;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsq_clkgen dut_i (
    .clk(clk), .rst(rst), .enable(enable), .load(load),
    .freq_word(freq_word), .ref_sel(ref_sel),
    .wave_out(wave_out), .freq_rb(freq_rb), .sel_rb(sel_rb)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_edges(input longint f, input int k, input int n);
    longint t = n >> k;
    return (t * f + 32768) >> 16;
  endfunction

  function automatic longint exp_switch(input longint f1, input longint f2,
                                        input int k, input int n1, input int ntot);
    longint s = 0;
    for (int i = 0; i < ntot; i++)
      if ((i % (1 << k)) == (1 << k) - 1) s += (i <= n1) ? f1 : f2;
    return (s + 32768) >> 16;
  endfunction

  task automatic do_load(input logic [15:0] f, input logic [2:0] k);
    @(negedge clk);
    load = 1; freq_word = f; ref_sel = k;
    @(posedge clk);
    @(negedge clk);
    load = 0;
    check(freq_rb == f, "R2 freq readback", freq_rb, f);
    check(sel_rb == k, "R2 sel readback", sel_rb, k);
  endtask

  // run n enabled edges from idle, count rising edges, then switch off
  task automatic run_window(input int n, output longint cnt);
    logic prev = 0;
    cnt = 0;
    @(negedge clk);
    enable = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wave_out && !prev) cnt++;
      prev = wave_out;
    end
    enable = 0;
    @(posedge clk);
    @(negedge clk);
    check(wave_out == 0, "R6 low after disable", wave_out, 0);
  endtask

  task automatic run_switch(input logic [15:0] f1, input logic [15:0] f2,
                            input logic [2:0] k, input int n1, input int ntot);
    logic prev = 0;
    longint cnt = 0;
    longint e;
    do_load(f1, k);
    @(negedge clk);
    enable = 1;
    for (int i = 0; i < ntot; i++) begin
      if (i == n1) begin load = 1; freq_word = f2; end
      @(posedge clk);
      @(negedge clk);
      load = 0;
      if (wave_out && !prev) cnt++;
      prev = wave_out;
    end
    enable = 0;
    @(posedge clk);
    @(negedge clk);
    e = exp_switch(f1, f2, k, n1, ntot);
    check(cnt == e, "R7 load while running", cnt, e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint c1, c2, e;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(wave_out == 0, "R1 wave reset", wave_out, 0);
    check(freq_rb == 0, "R1 freq_rb reset", freq_rb, 0);
    check(sel_rb == 0, "R1 sel_rb reset", sel_rb, 0);

    // R4 / R3 directed: full rate and divided rates
    do_load(16'd1000, 3'd0);
    run_window(2000, c1);
    e = exp_edges(1000, 0, 2000);
    check(c1 == e, "R4 count k0", c1, e);
    // R6 restart from phase zero gives same count
    run_window(2000, c2);
    check(c2 == c1, "R6 restart same count", c2, c1);

    do_load(16'd20000, 3'd7);
    run_window(3000, c1);
    e = exp_edges(20000, 7, 3000);
    check(c1 == e, "R3 count k7", c1, e);

    // R5 zero word
    do_load(16'd0, 3'd0);
    run_window(1000, c1);
    check(c1 == 0, "R5 zero word silent", c1, 0);

    // R9 half-scale word toggles every clock
    do_load(16'd32768, 3'd0);
    run_window(501, c1);
    check(c1 == 251, "R9 toggle each clock", c1, 251);

    // R2 inputs ignored without load
    do_load(16'd5000, 3'd2);
    @(negedge clk);
    freq_word = 16'd30000; ref_sel = 3'd0;
    @(posedge clk); @(negedge clk);
    check(freq_rb == 16'd5000, "R2 freq held without load", freq_rb, 5000);
    check(sel_rb == 3'd2, "R2 sel held without load", sel_rb, 2);
    run_window(2400, c1);
    e = exp_edges(5000, 2, 2400);
    check(c1 == e, "R2 wave uses loaded word", c1, e);

    // random runs
    for (int r = 0; r < 10; r++) begin
      logic [15:0] f;
      logic [2:0]  k;
      int n;
      f = 16'($urandom_range(1, 32767));
      k = 3'($urandom_range(0, 7));
      n = $urandom_range(500, 4000);
      do_load(f, k);
      run_window(n, c1);
      e = exp_edges(f, k, n);
      check(c1 == e, "R4 random count", c1, e);
    end

    // R7: load on a tick edge (m*2^k - 1) and at random edges
    run_switch(16'd3000, 16'd25000, 3'd0, 700, 1500);
    run_switch(16'd12000, 16'd400, 3'd3, (40 << 3) - 1, 1600);
    for (int r = 0; r < 4; r++) begin
      logic [2:0] k;
      int n1;
      k = 3'($urandom_range(0, 4));
      n1 = (($urandom_range(20, 60)) << k) - 1;
      run_switch(16'($urandom_range(1, 32767)), 16'($urandom_range(1, 32767)),
                 k, n1, n1 + 1200);
    end
    for (int r = 0; r < 3; r++)
      run_switch(16'($urandom_range(1, 32767)), 16'($urandom_range(1, 32767)),
                 3'($urandom_range(0, 5)), $urandom_range(100, 900), 1500);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule